// File: doc/BRIEF.md
# Disk Address Validate and Advance

This block keeps the 18-bit disk address register of a moving-head disk controller. The register packs a cylinder, a surface and a sector into fixed fields. The block checks each field against the drive geometry when software loads the register and again when a transfer is about to start. It also gives the linear word address on the pack that the current register value selects.

When a transfer finishes, the controller sends the number of words that moved. The block then works out the first sector after the last word touched, clipped at the end of the pack, and writes that position back as cylinder, surface and sector. The cylinder is held at the last real cylinder. Splitting the sector index by the sectors-per-cylinder constant is done by a sequential divider. A one-cycle done pulse marks the cycle in which the rewritten register is valid.

Top module: `dka_addr_track`

## Requirements
- R1: After reset the register and the word address read zero, and the error, end-of-pack and done outputs are low.
- R2: A load stores all 18 data bits in the register on the clock edge that samples it. The fields are: sector in bits 3:0, surface in bits 9:5 and cylinder in bits 17:10. The word address equals ((cylinder*20 + surface)*10 + sector)*256, and bit 4 does not affect it.
- R3: On the edge that takes a load, each field of the loaded data is checked. A one-cycle pulse is raised on the sector error output if the sector is 10 or more, on the surface error output if the surface is 20 or more, and on the cylinder error output if the cylinder is 203 or more. Each output is raised independently of the others.
- R4: A start-check strobe applies the same three range checks to the register contents, with the same one-cycle pulses, and leaves the register unchanged.
- R5: A transfer-complete strobe with N words sets the new sector index to ceil((word address + N)/256). The register becomes cylinder = index/200, surface = (index mod 200)/10 and sector = (index mod 200) mod 10. The done output pulses exactly 10 clock edges after the edge that samples the strobe, and the new value is visible in that same cycle.
- R6: After an advance the cylinder field never exceeds 202, because larger quotients are clamped to 202, and bit 4 reads zero.
- R7: If word address + N exceeds the drive size of 203*200*256 words, the end-of-pack output pulses together with done. The end position is then limited to the drive size, or to the start address if the start address already lies beyond the drive size. An end position exactly equal to the drive size does not raise end-of-pack.
- R8: While an advance is in progress, loads, start checks and further transfer strobes are ignored. They neither change the register nor raise error pulses.
- R9: When several strobes arrive in the same idle cycle, a load has priority over a transfer strobe, and a transfer strobe has priority over a start check. Any strobe that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Load strobe for the address register |
| load_data | input | 18 | Value to load |
| start_valid | input | 1 | Re-check the register fields before a transfer |
| xfer_valid | input | 1 | Transfer-complete strobe |
| xfer_words | input | 18 | Number of words moved by the transfer |
| addr_reg | output | 18 | Current address register |
| word_addr | output | 24 | Linear word address selected by the register |
| err_sect | output | 1 | Sector out of range pulse |
| err_surf | output | 1 | Surface out of range pulse |
| err_cyl | output | 1 | Cylinder out of range pulse |
| eop | output | 1 | End-of-pack pulse, coincident with done |
| adv_done | output | 1 | Register rewritten after a transfer |

## Verification
A wrong quotient or remainder inside the divider appears on the register as a wrong cylinder, surface or sector, in the same cycle that done rises. A stuck or miscounted step counter shows up as done arriving earlier or later than the tenth edge. A corrupted range check appears one cycle after the load or start as a missing or extra error pulse. A stale busy flag shows up as loads being dropped once the advance has ended, and this is visible as soon as the next load is sampled.

// File: rtl/dka_pkg.sv
package dka_pkg;

  localparam int REG_W  = 18;
  localparam int SECT_W = 4;
  localparam int SURF_W = 5;
  localparam int CYL_W  = 8;

  // field placement is fixed by the register layout seen by software
  typedef struct packed {
    logic [CYL_W-1:0]  cyl;
    logic [SURF_W-1:0] surf;
    logic              spare;
    logic [SECT_W-1:0] sect;
  } da_t;

  function automatic logic [31:0] sector_index(da_t a, logic [31:0] surfs, logic [31:0] sects);
    return ((32'(a.cyl) * surfs) + 32'(a.surf)) * sects + 32'(a.sect);
  endfunction

  function automatic logic [31:0] sectors_covering(logic [31:0] end_word, int wsh);
    logic [31:0] round;
    round = (32'd1 << wsh) - 32'd1;
    return (end_word + round) >> wsh;
  endfunction

  function automatic logic [31:0] clamp_to(logic [31:0] v, logic [31:0] lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/dka_field_check.sv
module dka_field_check #(
  parameter int NSECT = 10,
  parameter int NSURF = 20,
  parameter int NCYL  = 203,
  parameter int SECT_W = 4,
  parameter int SURF_W = 5,
  parameter int CYL_W  = 8
) (
  input  logic [SECT_W-1:0] sect_i,
  input  logic [SURF_W-1:0] surf_i,
  input  logic [CYL_W-1:0]  cyl_i,
  output logic              bad_sect_o,
  output logic              bad_surf_o,
  output logic              bad_cyl_o
);
  assign bad_sect_o = 32'(sect_i) >= 32'(NSECT);
  assign bad_surf_o = 32'(surf_i) >= 32'(NSURF);
  assign bad_cyl_o  = 32'(cyl_i)  >= 32'(NCYL);
endmodule

// File: rtl/dka_div_seq.sv
module dka_div_seq #(
  parameter int DIVISOR = 200,
  parameter int DVD_W   = 16,
  parameter int QUO_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  output logic             done_o,
  output logic [QUO_W-1:0] quot_o,
  output logic [DVD_W-1:0] rem_o
);
  localparam int BI_W = (QUO_W > 1) ? $clog2(QUO_W) : 1;
  localparam int TR_W = DVD_W + QUO_W;

  logic             busy_q;
  logic [BI_W-1:0]  bit_q;
  logic [DVD_W-1:0] rem_q;
  logic [QUO_W-1:0] quot_q;
  logic [TR_W-1:0]  trial;
  logic             take;

  assign trial = TR_W'(DIVISOR) << bit_q;
  assign take  = TR_W'(rem_q) >= trial;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bit_q  <= '0;
      rem_q  <= '0;
      quot_q <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        bit_q  <= BI_W'(QUO_W - 1);
        rem_q  <= dividend_i;
        quot_q <= '0;
      end else if (busy_q) begin
        if (take) begin
          rem_q         <= DVD_W'(TR_W'(rem_q) - trial);
          quot_q[bit_q] <= 1'b1;
        end
        if (bit_q == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          bit_q <= bit_q - 1'b1;
        end
      end
    end
  end

  assign quot_o = quot_q;
  assign rem_o  = rem_q;

  // R5: the remainder left by the divider is always a proper remainder
  assert_div_rem_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (32'(rem_q) < 32'(DIVISOR)));

  // R5: a result appears only after a run that was started
  assert_div_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_q));
endmodule

// File: rtl/dka_addr_track.sv
module dka_addr_track import dka_pkg::*; #(
  parameter int WORDS_PER_SECT = 256,
  parameter int SECTS_PER_SURF = 10,
  parameter int SURFS_PER_CYL  = 20,
  parameter int NUM_CYL        = 203,
  parameter int NWORD_W        = 18,
  parameter int ADDR_OUT_W     = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_valid,
  input  logic [REG_W-1:0]      load_data,
  input  logic                  start_valid,
  input  logic                  xfer_valid,
  input  logic [NWORD_W-1:0]    xfer_words,
  output logic [REG_W-1:0]      addr_reg,
  output logic [ADDR_OUT_W-1:0] word_addr,
  output logic                  err_sect,
  output logic                  err_surf,
  output logic                  err_cyl,
  output logic                  eop,
  output logic                  adv_done
);
  localparam int WSH           = $clog2(WORDS_PER_SECT);
  localparam int SECTS_PER_CYL = SECTS_PER_SURF * SURFS_PER_CYL;
  localparam int DRIVE_WORDS   = NUM_CYL * SECTS_PER_CYL * WORDS_PER_SECT;
  localparam int MAX_IDX       = (((2**CYL_W) - 1) * SURFS_PER_CYL + (2**SURF_W) - 1)
                                 * SECTS_PER_SURF + (2**SECT_W);
  localparam int IDX_W         = $clog2(MAX_IDX + 1);
  localparam int QUO_W         = $clog2(MAX_IDX / SECTS_PER_CYL + 1);
  localparam logic [31:0] DRIVE_U    = 32'(DRIVE_WORDS);
  localparam logic [31:0] LAST_CYL_U = 32'(NUM_CYL - 1);

  da_t cur_q;
  logic adv_active_q, eop_hold_q, adv_done_q, eop_q;
  logic err_sect_q, err_surf_q, err_cyl_q;

  // strobe arbitration: load > transfer > start, all dropped while advancing
  logic idle, load_fire, xfer_fire, start_fire, chk_fire;
  assign idle       = !adv_active_q;
  assign load_fire  = idle && load_valid;
  assign xfer_fire  = idle && xfer_valid && !load_valid;
  assign start_fire = idle && start_valid && !load_valid && !xfer_valid;
  assign chk_fire   = load_fire || start_fire;

  // range check on whichever value the accepted strobe refers to
  da_t chk_src;
  logic bad_sect, bad_surf, bad_cyl;
  assign chk_src = load_valid ? da_t'(load_data) : cur_q;

  dka_field_check #(
    .NSECT(SECTS_PER_SURF), .NSURF(SURFS_PER_CYL), .NCYL(NUM_CYL),
    .SECT_W(SECT_W), .SURF_W(SURF_W), .CYL_W(CYL_W)
  ) u_check (
    .sect_i(chk_src.sect), .surf_i(chk_src.surf), .cyl_i(chk_src.cyl),
    .bad_sect_o(bad_sect), .bad_surf_o(bad_surf), .bad_cyl_o(bad_cyl)
  );

  // linear position of the current register
  logic [31:0] wa_full;
  assign wa_full   = sector_index(cur_q, 32'(SURFS_PER_CYL), 32'(SECTS_PER_SURF)) << WSH;
  assign word_addr = ADDR_OUT_W'(wa_full);

  // end of transfer, clipped to the pack, rounded up to whole sectors
  logic [31:0] end_raw, end_lim;
  logic past_end;
  logic [IDX_W-1:0] idx_n;
  assign end_raw  = wa_full + 32'(xfer_words);
  assign past_end = end_raw > DRIVE_U;
  assign end_lim  = !past_end ? end_raw : ((wa_full > DRIVE_U) ? wa_full : DRIVE_U);
  assign idx_n    = IDX_W'(sectors_covering(end_lim, WSH));

  logic div_done;
  logic [QUO_W-1:0] div_quot;
  logic [IDX_W-1:0] div_rem;

  dka_div_seq #(.DIVISOR(SECTS_PER_CYL), .DVD_W(IDX_W), .QUO_W(QUO_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(xfer_fire), .dividend_i(idx_n),
    .done_o(div_done), .quot_o(div_quot), .rem_o(div_rem)
  );

  // re-split the divider result into register fields
  da_t adv_next;
  always_comb begin
    adv_next       = '0;
    adv_next.cyl   = CYL_W'(clamp_to(32'(div_quot), LAST_CYL_U));
    adv_next.surf  = SURF_W'(32'(div_rem) / 32'(SECTS_PER_SURF));
    adv_next.sect  = SECT_W'(32'(div_rem) % 32'(SECTS_PER_SURF));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q        <= '0;
      adv_active_q <= 1'b0;
      eop_hold_q   <= 1'b0;
      adv_done_q   <= 1'b0;
      eop_q        <= 1'b0;
      err_sect_q   <= 1'b0;
      err_surf_q   <= 1'b0;
      err_cyl_q    <= 1'b0;
    end else begin
      adv_done_q <= 1'b0;
      eop_q      <= 1'b0;
      err_sect_q <= chk_fire && bad_sect;
      err_surf_q <= chk_fire && bad_surf;
      err_cyl_q  <= chk_fire && bad_cyl;
      if (load_fire) cur_q <= da_t'(load_data);
      if (xfer_fire) begin
        adv_active_q <= 1'b1;
        eop_hold_q   <= past_end;
      end
      if (div_done && adv_active_q) begin
        cur_q        <= adv_next;
        adv_active_q <= 1'b0;
        adv_done_q   <= 1'b1;
        eop_q        <= eop_hold_q;
      end
    end
  end

  assign addr_reg = cur_q;
  assign adv_done = adv_done_q;
  assign eop      = eop_q;
  assign err_sect = err_sect_q;
  assign err_surf = err_surf_q;
  assign err_cyl  = err_cyl_q;

  // R6: clamped cylinder and cleared spare bit after every advance
  assert_cyl_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_done |-> (32'(addr_reg[17:10]) <= LAST_CYL_U));
  assert_spare_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_done |-> (addr_reg[4] == 1'b0));

  // R5: surface and sector written by an advance are in range
  assert_fields_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv_done |-> ((32'(addr_reg[3:0]) < 32'(SECTS_PER_SURF)) &&
                  (32'(addr_reg[9:5]) < 32'(SURFS_PER_CYL))));

  // R3/R4: an error pulse always follows an accepted load or start check
  assert_err_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sect || err_surf || err_cyl) |-> $past(chk_fire));

  // R7: end-of-pack only ever accompanies done
  assert_eop_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> adv_done);

  // R8: the register holds while an advance is pending
  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_active_q && !div_done) |=> $stable(addr_reg));
endmodule

// File: tb/tb_dka_addr_track.sv
module tb_dka_addr_track;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [17:0] load_data = '0;
  logic        start_valid = 1'b0;
  logic        xfer_valid = 1'b0;
  logic [17:0] xfer_words = '0;
  logic [17:0] addr_reg;
  logic [23:0] word_addr;
  logic        err_sect, err_surf, err_cyl, eop, adv_done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dka_addr_track dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .start_valid(start_valid), .xfer_valid(xfer_valid), .xfer_words(xfer_words),
    .addr_reg(addr_reg), .word_addr(word_addr), .err_sect(err_sect),
    .err_surf(err_surf), .err_cyl(err_cyl), .eop(eop), .adv_done(adv_done)
  );

  typedef struct packed {
    logic [17:0] ld;
    logic [17:0] n;
    logic [17:0] exp_reg;
    logic        exp_eop;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{18'd0,      18'd256,    18'd1,      1'b0},
    '{18'd9,      18'd256,    18'd32,     1'b0},
    '{18'd617,    18'd1,      18'd1024,   1'b0},
    '{18'd5220,   18'd0,      18'd5220,   1'b0},
    '{18'd207465, 18'd512,    18'd206848, 1'b1},
    '{18'd207465, 18'd256,    18'd206848, 1'b0},
    '{18'd1024,   18'd300,    18'd1026,   1'b0},
    '{18'd262127, 18'd10,     18'd207237, 1'b1},
    '{18'd16,     18'd0,      18'd0,      1'b0},
    '{18'd0,      18'd262143, 18'd5188,   1'b0}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench-side word address: fields pulled apart by division, not slicing
  function automatic longint model_wa(input longint d);
    longint sect, surf, cyl;
    sect = d % 16;
    surf = (d / 32) % 32;
    cyl  = d / 1024;
    return (cyl * 200 + surf * 10 + sect) * 256;
  endfunction

  task automatic do_load(input logic [17:0] d);
    @(negedge clk);
    load_valid = 1'b1; load_data = d;
    @(negedge clk);
    load_valid = 1'b0;
    chk("R2 load value", addr_reg, d);
    chk("R2 word address", word_addr, model_wa(d));
    chk("R3 sector error", err_sect, (d % 16) >= 10);
    chk("R3 surface error", err_surf, ((d / 32) % 32) >= 20);
    chk("R3 cylinder error", err_cyl, (d / 1024) >= 203);
  endtask

  task automatic do_adv(input logic [17:0] n, input logic [17:0] exp_reg, input logic exp_eop);
    logic early;
    early = 1'b0;
    @(negedge clk);
    xfer_valid = 1'b1; xfer_words = n;
    @(negedge clk);
    xfer_valid = 1'b0;
    if (adv_done) early = 1'b1;
    for (int i = 2; i <= 10; i++) begin
      @(negedge clk);
      if (adv_done) early = 1'b1;
    end
    @(negedge clk);
    chk("R5 done not early", early, 0);
    chk("R5 done latency", adv_done, 1);
    chk("R5 R6 advanced register", addr_reg, exp_reg);
    chk("R7 end of pack", eop, exp_eop);
    chk("R6 spare bit", addr_reg[4], 0);
  endtask

  initial begin
    #(10 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset register", addr_reg, 0);
    chk("R1 reset word address", word_addr, 0);
    chk("R1 reset pulses", {err_sect, err_surf, err_cyl, eop, adv_done}, 0);

    // table walk: load, then advance
    for (int v = 0; v < NV; v++) begin
      do_load(VEC[v].ld);
      do_adv(VEC[v].n, VEC[v].exp_reg, VEC[v].exp_eop);
    end

    // R3 each field boundary separately
    do_load(18'd10);
    do_load(18'd640);
    do_load(18'd207872);
    do_load(18'd207465);

    // R4 start check on a bad surface, register untouched
    do_load(18'd640);
    @(negedge clk); start_valid = 1'b1;
    @(negedge clk); start_valid = 1'b0;
    chk("R4 start surface error", err_surf, 1);
    chk("R4 start sector error", err_sect, 0);
    chk("R4 register unchanged", addr_reg, 640);
    @(negedge clk);
    chk("R4 pulse one cycle", err_surf, 0);

    // R4 start check on a valid register
    do_load(18'd5220);
    @(negedge clk); start_valid = 1'b1;
    @(negedge clk); start_valid = 1'b0;
    chk("R4 no errors on valid", {err_sect, err_surf, err_cyl}, 0);

    // R8 load during an advance is dropped
    do_load(18'd0);
    @(negedge clk); xfer_valid = 1'b1; xfer_words = 18'd256;
    @(negedge clk); xfer_valid = 1'b0; load_valid = 1'b1; load_data = 18'd10;
    @(negedge clk); load_valid = 1'b0;
    chk("R8 no error pulse while busy", err_sect, 0);
    chk("R8 register held while busy", addr_reg, 0);
    repeat (9) @(negedge clk);
    chk("R8 done after ignored load", adv_done, 1);
    chk("R8 advance result kept", addr_reg, 1);

    // R9 load beats transfer in the same cycle
    @(negedge clk);
    load_valid = 1'b1; load_data = 18'd32; xfer_valid = 1'b1; xfer_words = 18'd256;
    @(negedge clk);
    load_valid = 1'b0; xfer_valid = 1'b0;
    chk("R9 load taken", addr_reg, 32);
    seen = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (adv_done) seen = 1'b1;
    end
    chk("R9 transfer dropped", seen, 0);
    chk("R9 register kept", addr_reg, 32);

    // R9 transfer beats start check
    do_load(18'd640);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_words = 18'd0; start_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0; start_valid = 1'b0;
    chk("R9 start dropped", err_surf, 0);
    repeat (10) @(negedge clk);
    chk("R9 transfer ran", adv_done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule